// File: doc/BRIEF.md
# Up/Down Event Timer

A 16-bit general-purpose timer that sits on a simple synchronous register bus. It counts up or down, one step each time an 8-bit prescaler reaches its limit. The prescaler runs from one of four clock-enable inputs. In periodic mode the counter restarts from a programmable load value. In free-running mode it wraps through the whole 16-bit range. Each time the count passes its terminal value, the timer sets a sticky interrupt flag.

One of 32 event inputs can be selected. When the selected event fires, the timer can latch the live count into a capture register, restart the counter and prescaler, or both. The count reaches the readable value register through a two-stage synchronizer. A bypass bit removes the synchronizer stages and also forces the prescaler to divide by one.

A load write that arrives in the same cycle as a timeout is held back for one cycle. The timeout therefore reloads the old value. In periodic mode, an interrupt-clear write can also reload the counter.

Top module: `updown_event_timer`

## Requirements
- R1: The register words are at these bus_addr values: 0 load (read/write), 1 value (read only), 2 control (read/write), 3 clear (write only, reads 0), 4 capture (read only). After reset, control reads 0x000A, the other registers read 0 and irq is 0. The control fields are:
  - [1:0] prescale select
  - [2] count up (1) or down (0)
  - [3] periodic (1) or free-running (0)
  - [4] enable
  - [6:5] clock source select
  - [7] reload on clear
  - [12:8] event select
  - [13] capture enable
  - [14] event reset enable
  - [15] sync bypass
- R2: In periodic mode the counter starts at the load value. Counting up, it steps from 0xFFFF back to the load value. Counting down, it steps from 0x0000 back to the load value.
- R3: In free-running mode the load value is ignored. The counter starts at 0x0000 when counting up and at 0xFFFF when counting down, and it wraps through the full 16-bit range.
- R4: A load write in the same cycle as a timeout does not affect that timeout's reload. It takes effect one cycle later.
- R5: With capture enabled, an active event on the selected input latches the count held in that cycle into the capture register. Other event inputs have no effect, and so does the selected input while capture is disabled.
- R6: With event reset enabled, an active selected event restarts the counter at its start value and clears the prescaler.
- R7: In periodic mode with reload-on-clear set, a clear write with bit 0 set reloads the counter with the load value. With reload-on-clear clear, the count continues.
- R8: Without bypass, the value register shows the count from two clock cycles earlier. With bypass, it shows the live count.
- R9: The prescaler divides by 1, 4, 16 or 256 for prescale select 0 to 3. Bypass forces division by 1.
- R10: The counter advances only on cycles in which the src_tick bit chosen by the clock source select is high.
- R11: A timeout sets irq, and irq stays set until a clear write with bit 0 set. A clear write with bit 0 at 0 leaves irq set. A timeout in the same cycle as a clear leaves irq set.
- R12: While enable is 0, the counter and prescaler are held at 0. The first enabled cycle loads the start value. Each later enabled cycle may advance the count.
- R13: Writes to the value and capture addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counter |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| src_tick | input | 4 | Clock-enable inputs, one per clock source |
| evt_in | input | 32 | Event inputs, active high for one cycle |
| irq | output | 1 | Sticky timeout interrupt |

## Verification
The main counting function is run from a vector table that covers every combination of direction and mode. The table includes load values next to the terminal value, so that wrap and timeout-reload cases separate periodic reload from free-running wrap, and up counting from down counting. A load value of 0 while counting down gives a period of one, which makes every step a timeout.

The same free-running count is read with and without bypass, which tells the two-cycle synchronizer lag apart from the live path. Each prescale select is run for a known number of cycles, so each division ratio gives a distinct count.

Event pulses are applied on the selected input, on a neighbouring input, and with capture disabled, to show that capture and event reset respond only to the configured input. A load write placed exactly on a timeout shows whether the reload used the old value or the new one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int PSC_W  = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_EVT = 32;
    localparam int NUM_SRC = 4;

    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_VALUE = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLEAR = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;

    localparam logic [15:0] CTRL_RESET = 16'h000A;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV4   = 2'd1,
        PS_DIV16  = 2'd2,
        PS_DIV256 = 2'd3
    } psc_sel_e;

    typedef struct packed {
        logic       bypass;
        logic       evt_rst;
        logic       cap_en;
        logic [4:0] evt_sel;
        logic       clr_reload;
        logic [1:0] clk_sel;
        logic       enable;
        logic       periodic;
        logic       count_up;
        psc_sel_e   psc_sel;
    } ctrl_t;

    // last prescaler count before the counter steps
    function automatic logic [PSC_W-1:0] psc_limit(input psc_sel_e sel, input logic bypass);
        logic [PSC_W-1:0] lim;
        if (bypass) begin
            lim = '0;
        end else begin
            unique case (sel)
                PS_DIV1:   lim = 8'd0;
                PS_DIV4:   lim = 8'd3;
                PS_DIV16:  lim = 8'd15;
                default:   lim = 8'd255;
            endcase
        end
        return lim;
    endfunction

    function automatic logic [CNT_W-1:0] start_value(input logic periodic, input logic up,
                                                     input logic [CNT_W-1:0] ld);
        if (periodic) return ld;
        return up ? '0 : '1;
    endfunction

endpackage

// File: rtl/tmr_readsync.sv
module tmr_readsync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         bypass,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = bypass ? din : stg[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int NEVT = NUM_EVT,
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst,
    input  ctrl_t           ctrl,
    input  logic [CW-1:0]   load,
    input  logic [NSRC-1:0] src_tick,
    input  logic [NEVT-1:0] evt_in,
    input  logic            clr_pulse,
    output logic [CW-1:0]   count,
    output logic [CW-1:0]   capture,
    output logic [PSC_W-1:0] psc,
    output logic            run,
    output logic            evt_hit,
    output logic            timeout
);
    logic             tick, adv, at_term, ev_rst, clr_rl;
    logic [PSC_W-1:0] lim;
    logic [CW-1:0]    restart, stepped;

    always_comb begin
        tick    = src_tick[ctrl.clk_sel];
        evt_hit = evt_in[ctrl.evt_sel];
        lim     = psc_limit(ctrl.psc_sel, ctrl.bypass);
        restart = start_value(ctrl.periodic, ctrl.count_up, load);
        ev_rst  = run & ctrl.enable & ctrl.evt_rst & evt_hit;
        clr_rl  = run & ctrl.enable & ctrl.periodic & ctrl.clr_reload & clr_pulse;
        adv     = run & ctrl.enable & tick & (psc >= lim);
        at_term = ctrl.count_up ? (count == '1) : (count == '0);
        timeout = adv & at_term & ~ev_rst & ~clr_rl;
        if (at_term)            stepped = restart;
        else if (ctrl.count_up) stepped = count + 1'b1;
        else                    stepped = count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.enable) begin
            count <= '0;
            psc   <= '0;
            run   <= 1'b0;
        end else if (!run) begin
            run   <= 1'b1;
            count <= restart;
            psc   <= '0;
        end else begin
            if (ev_rst)      psc <= '0;
            else if (tick)   psc <= (psc >= lim) ? '0 : psc + 1'b1;

            if (ev_rst)      count <= restart;
            else if (clr_rl) count <= load;
            else if (adv)    count <= stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            capture <= '0;
        else if (run && ctrl.enable && ctrl.cap_en && evt_hit)
            capture <= count;
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              timeout,
    input  logic [CW-1:0]     value_rd,
    input  logic [CW-1:0]     capture,
    output ctrl_t             ctrl,
    output logic [CW-1:0]     load,
    output logic              load_wr,
    output logic              clr_pulse,
    output logic              irq,
    output logic [15:0]       rdata
);
    logic          pend;
    logic [CW-1:0] pend_val;

    assign load_wr   = wr_en && (addr == A_LOAD);
    assign clr_pulse = wr_en && (addr == A_CLEAR) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= ctrl_t'(CTRL_RESET);
        end else if (wr_en && addr == A_CTRL) begin
            ctrl <= ctrl_t'(wdata);
        end
    end

    // a load landing on a timeout waits one cycle so the reload sees the old value
    always_ff @(posedge clk) begin
        if (rst) begin
            load     <= '0;
            pend     <= 1'b0;
            pend_val <= '0;
        end else begin
            if (pend) begin
                load <= pend_val;
                pend <= 1'b0;
            end
            if (load_wr) begin
                if (timeout) begin
                    pend     <= 1'b1;
                    pend_val <= wdata[CW-1:0];
                end else begin
                    load <= wdata[CW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            irq <= 1'b0;
        else if (timeout)   irq <= 1'b1;
        else if (clr_pulse) irq <= 1'b0;
    end

    always_comb begin
        unique case (addr)
            A_LOAD:  rdata = load;
            A_VALUE: rdata = value_rd;
            A_CTRL:  rdata = ctrl;
            A_CAPT:  rdata = capture;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/updown_event_timer.sv
module updown_event_timer
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    input  logic [NUM_SRC-1:0]    src_tick,
    input  logic [NUM_EVT-1:0]    evt_in,
    output logic                  irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q, count, capture_q, value_rd;
    logic [PSC_W-1:0] psc;
    logic             run, evt_hit, timeout, load_wr, clr_pulse;
    logic             en_bit, cap_bit, ers_bit, byp_bit;

    assign en_bit  = ctrl_q.enable;
    assign cap_bit = ctrl_q.cap_en;
    assign ers_bit = ctrl_q.evt_rst;
    assign byp_bit = ctrl_q.bypass;

    tmr_regs #(.CW(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(bus_sel & bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .timeout(timeout), .value_rd(value_rd), .capture(capture_q),
        .ctrl(ctrl_q), .load(load_q), .load_wr(load_wr),
        .clr_pulse(clr_pulse), .irq(irq), .rdata(bus_rdata)
    );

    tmr_core #(.CW(CNT_W), .NEVT(NUM_EVT), .NSRC(NUM_SRC)) u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .load(load_q),
        .src_tick(src_tick), .evt_in(evt_in), .clr_pulse(clr_pulse),
        .count(count), .capture(capture_q), .psc(psc), .run(run),
        .evt_hit(evt_hit), .timeout(timeout)
    );

    tmr_readsync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(count), .bypass(byp_bit), .dout(value_rd)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
    input logic        clk,
    input logic        rst,
    input logic        irq,
    input logic        timeout,
    input logic        clr_pulse,
    input logic        load_wr,
    input logic [15:0] load_q,
    input logic [15:0] count,
    input logic [15:0] capture_q,
    input logic [15:0] value_rd,
    input logic [7:0]  psc,
    input logic        run,
    input logic        evt_hit,
    input logic        en_bit,
    input logic        cap_bit,
    input logic        ers_bit,
    input logic        byp_bit
);
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 1'b1;
    end

    AST_TIMEOUT_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
        timeout |=> irq); // R11
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq && !clr_pulse |=> irq); // R11
    AST_LOAD_HELD_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        timeout && load_wr |=> load_q == $past(load_q)); // R4
    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (rst)
        run && en_bit && cap_bit && evt_hit |=> capture_q == $past(count)); // R5
    AST_EVENT_CLEARS_PSC: assert property (@(posedge clk) disable iff (rst)
        run && en_bit && ers_bit && evt_hit |=> psc == 8'd0); // R6
    AST_VALUE_LAG: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) && !byp_bit |-> value_rd == $past(count, 2)); // R8
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en_bit |=> count == 16'd0 && psc == 8'd0); // R12
endmodule

bind updown_event_timer tmr_checker u_chk (
    .clk(clk), .rst(rst), .irq(irq), .timeout(timeout), .clr_pulse(clr_pulse),
    .load_wr(load_wr), .load_q(load_q), .count(count), .capture_q(capture_q),
    .value_rd(value_rd), .psc(psc), .run(run), .evt_hit(evt_hit),
    .en_bit(en_bit), .cap_bit(cap_bit), .ers_bit(ers_bit), .byp_bit(byp_bit)
);

// File: tb/tb_updown_event_timer.sv
`timescale 1ns/1ps
module tb_updown_event_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  src_tick = 4'b0001;
    logic [31:0] evt_in = '0;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    updown_event_timer dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .evt_in(evt_in), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] load;
        logic [15:0] n;
    } vec_t;

    // all with enable + bypass, source 0
    localparam vec_t VECS [8] = '{
        '{16'h8014, 16'h0000, 16'd20},   // free up
        '{16'h8010, 16'h0000, 16'd20},   // free down
        '{16'h801C, 16'h1234, 16'd50},   // periodic up
        '{16'h801C, 16'hFFFC, 16'd11},   // periodic up, wraps
        '{16'h8018, 16'h0003, 16'd11},   // periodic down, wraps
        '{16'h8018, 16'h0100, 16'd30},   // periodic down
        '{16'h8014, 16'h7777, 16'd5},    // free up, load ignored
        '{16'h8018, 16'h0000, 16'd6}     // periodic down, period one
    };

    function automatic int period_of(logic [15:0] c, logic [15:0] l);
        if (!c[3]) return 65536;
        if (c[2])  return 65536 - int'(l);
        return int'(l) + 1;
    endfunction

    function automatic logic [15:0] exp_count(logic [15:0] c, logic [15:0] l, int n);
        int r;
        r = (n - 1) % period_of(c, l);
        if (c[3]) return c[2] ? 16'(int'(l) + r) : 16'(int'(l) - r);
        return c[2] ? 16'(r) : 16'(65535 - r);
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int idx);
        evt_in[idx] = 1'b1;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic stop_and_clear();
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0001);
        wait_n(3);
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, d); chk("R1 ctrl reset", d, 16'h000A);
        rd(3'd0, d); chk("R1 load reset", d, 16'h0000);
        rd(3'd1, d); chk("R1 value reset", d, 16'h0000);
        rd(3'd4, d); chk("R1 capture reset", d, 16'h0000);
        chk("R1 irq reset", {15'd0, irq}, 16'd0);

        // table walk: R2 periodic / R3 free-running, R11 timeout flag
        foreach (VECS[i]) begin
            string tag;
            tag = VECS[i].ctrl[3] ? "R2" : "R3";
            wr(3'd0, VECS[i].load);
            wr(3'd2, VECS[i].ctrl);
            wait_n(int'(VECS[i].n));
            rd(3'd1, d);
            chk($sformatf("%s vec%0d count", tag, i), d,
                exp_count(VECS[i].ctrl, VECS[i].load, int'(VECS[i].n)));
            chk($sformatf("R11 vec%0d irq", i), {15'd0, irq},
                {15'd0, (int'(VECS[i].n) - 1) >= period_of(VECS[i].ctrl, VECS[i].load)});
            stop_and_clear();
            chk($sformatf("R11 vec%0d irq cleared", i), {15'd0, irq}, 16'd0);
        end

        // R8 synchronizer lag vs bypass
        wr(3'd2, 16'h0014); wait_n(10);
        rd(3'd1, d); chk("R8 lagged value", d, 16'd7);
        wr(3'd2, 16'h0000); wait_n(3);
        rd(3'd1, d); chk("R12 disable clears value", d, 16'd0);
        wr(3'd2, 16'h8014); wait_n(10);
        rd(3'd1, d); chk("R8 bypass live value", d, 16'd9);
        stop_and_clear();

        // R9 prescaler ratios
        wr(3'd2, 16'h0016); wait_n(40);
        rd(3'd1, d); chk("R9 divide by 16", d, 16'd2);
        stop_and_clear();
        wr(3'd2, 16'h0015); wait_n(20);
        rd(3'd1, d); chk("R9 divide by 4", d, 16'd4);
        stop_and_clear();
        wr(3'd2, 16'h8017); wait_n(40);
        rd(3'd1, d); chk("R9 bypass forces divide by 1", d, 16'd39);
        stop_and_clear();

        // R10 clock source select
        wr(3'd2, 16'h8034); wait_n(10);
        rd(3'd1, d); chk("R10 idle source stalls", d, 16'd0);
        stop_and_clear();
        src_tick = 4'b0100;
        wr(3'd2, 16'h8054); wait_n(10);
        rd(3'd1, d); chk("R10 source 2 counts", d, 16'd9);
        stop_and_clear();
        src_tick = 4'b0001;

        // R5 capture on selected event 5
        wr(3'd2, 16'hA514); wait_n(7);
        pulse(5);
        rd(3'd4, d); chk("R5 capture value", d, 16'd6);
        pulse(6);
        rd(3'd4, d); chk("R5 other event ignored", d, 16'd6);
        wr(3'd2, 16'h8514);
        pulse(5);
        rd(3'd4, d); chk("R5 capture disabled", d, 16'd6);
        stop_and_clear();

        // R13 writes to read-only words
        wr(3'd1, 16'h1234);
        rd(3'd1, d); chk("R13 value write ignored", d, 16'd0);
        wr(3'd4, 16'h5555);
        rd(3'd4, d); chk("R13 capture write ignored", d, 16'd6);

        // R6 event reset
        wr(3'd2, 16'hC514); wait_n(7);
        pulse(5);
        wait_n(4);
        rd(3'd1, d); chk("R6 event restarts count", d, 16'd4);
        stop_and_clear();

        // R7 reload on clear
        wr(3'd0, 16'h1000);
        wr(3'd2, 16'h809C); wait_n(9);
        wr(3'd3, 16'h0001);
        rd(3'd1, d); chk("R7 clear reloads", d, 16'h1000);
        wait_n(3);
        rd(3'd1, d); chk("R7 counts after reload", d, 16'h1003);
        stop_and_clear();
        wr(3'd2, 16'h801C); wait_n(9);
        wr(3'd3, 16'h0001);
        rd(3'd1, d); chk("R7 clear without reload bit", d, 16'h1009);
        stop_and_clear();

        // R4 load write on a timeout
        wr(3'd0, 16'hFFFE);
        wr(3'd2, 16'h801C); wait_n(2);
        wr(3'd0, 16'h8000);
        rd(3'd1, d); chk("R4 reload uses old load", d, 16'hFFFE);
        wait_n(2);
        rd(3'd1, d); chk("R4 next reload uses new load", d, 16'h8000);
        rd(3'd0, d); chk("R4 load readback", d, 16'h8000);
        wr(3'd2, 16'h0000);
        chk("R11 irq held after timeout", {15'd0, irq}, 16'd1);
        wr(3'd3, 16'h0002);
        chk("R11 clear without bit0 keeps irq", {15'd0, irq}, 16'd1);
        wr(3'd3, 16'h0001);
        chk("R11 clear bit0 drops irq", {15'd0, irq}, 16'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule